// File: doc/BRIEF.md
# Replayable Word FIFO with Occupancy Flags

This block is a first-in/first-out buffer for 9-bit words: 8 data bits plus one spare bit that the user may use for parity or control. A write strobe stores the word on the input bus. A read strobe brings the oldest stored word out on the output bus. Two circular pointers advance inside the block, so the user never supplies an address. Three flags report the occupancy. Empty blocks reads, so the buffer cannot underflow. Full blocks writes, so it cannot overflow. Half-full tells a producer or consumer that more than half the storage is in use.

A replay input rewinds the read position to the first word stored since reset, so the whole stream can be read again. The write position does not move. The number of stored words is recomputed as the distance from the start of the buffer to the write position. Replay gives a correct result only while fewer words than the depth have been written since reset. The depth is a parameter (256, 512 or 1024 words). A synchronous active-high reset empties the buffer. All strobes are sampled on the rising clock edge, and a read and a write in the same cycle both take effect when the flags allow them.

Top module: `replay_fifo`

## Requirements
- R1: A cycle with `rst` high clears both positions: after it, `empty`=1, `full`=0, `half_full`=0 and `rd_data`=0.
- R2: Words come out on `rd_data` in the order they were written, with all 9 bits intact. `rd_data` changes one clock edge after a cycle with `rd_en`=1 that is accepted, and it holds its value in every other cycle.
- R3: A write while `full`=1 with `rd_en`=0 is ignored. No stored word changes and `full` stays 1.
- R4: A read while `empty`=1 with `wr_en`=0 is ignored. `rd_data` keeps its value and `empty` stays 1.
- R5: `half_full` is 1 exactly when more than DEPTH/2 words are stored. With DEPTH/2 words stored it is 0.
- R6: `empty` is 1 exactly when no word is stored, and `full` is 1 exactly when DEPTH words are stored.
- R7: When the buffer is neither empty nor full, a read and a write in the same cycle both happen, and the number of stored words stays the same.
- R8: When the buffer is empty, a read and a write in the same cycle perform only the write. `rd_data` holds its value and `empty` falls.
- R9: When the buffer is full, a read and a write in the same cycle both happen. The oldest word is read out, the new word is stored, and `full` stays 1.
- R10: A cycle with `rewind_n`=0 moves the read position back to the first word written since reset. It leaves the write position unchanged and ignores `wr_en` and `rd_en` in that cycle. The stored count becomes the number of words written since reset, which must be fewer than DEPTH.
- R11: The positions wrap around the storage, so streams longer than DEPTH words keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset that empties the buffer |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH (9) | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH (9) | Last word read out, registered |
| rewind_n | input | 1 | Active-low replay request that rewinds the read position |
| empty | output | 1 | No word stored |
| half_full | output | 1 | More than DEPTH/2 words stored |
| full | output | 1 | DEPTH words stored |

## Verification
The bench builds the block with DEPTH=256 and WIDTH=9, the smallest supported depth. This keeps filling to capacity, the half-full threshold at 128 and 129 words, and pointer wrap-around within a few hundred cycles. Data patterns set bit 8 so that the spare ninth bit is carried through. The replay test writes only 10 words after reset, so it stays inside the range where the recomputed count is correct.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

    localparam int WORD_W = 9;

    // Per-cycle decision taken by the control logic.
    typedef struct packed {
        logic rewind;
        logic push;
        logic pop;
    } fifo_op_t;

    // A rewind cycle ignores both strobes. A write is allowed unless the
    // buffer is full and no read frees a slot in the same cycle. A read
    // needs at least one stored word.
    function automatic fifo_op_t decide_op(
        input logic wr_req,
        input logic rd_req,
        input logic rewind_req,
        input logic is_empty,
        input logic is_full
    );
        fifo_op_t op;
        op.rewind = rewind_req;
        op.push   = !rewind_req && wr_req && (!is_full || rd_req);
        op.pop    = !rewind_req && rd_req && !is_empty;
        return op;
    endfunction

    function automatic bit depth_supported(input int d);
        return (d == 256) || (d == 512) || (d == 1024);
    endfunction

endpackage

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read: a same-edge write to the read slot (full buffer,
    // both strobes) still returns the old word.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rewind_n,
    input  logic          is_empty,
    input  logic          is_full,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW:0]   occ
);

    fifo_op_t op;

    always_comb begin
        op = decide_op(wr_en, rd_en, !rewind_n, is_empty, is_full);
    end

    assign push = op.push;
    assign pop  = op.pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else if (op.rewind) begin
            rd_ptr <= '0;
            occ    <= {1'b0, wr_ptr};
        end else begin
            if (op.push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (op.pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({op.push, op.pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

endmodule

// File: rtl/replay_fifo_flags.sv
module replay_fifo_flags #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [AW:0] occ,
    output logic        empty,
    output logic        half_full,
    output logic        full
);

    localparam int          CW     = AW + 1;
    localparam logic [AW:0] FULL_C = CW'(DEPTH);
    localparam logic [AW:0] HALF_C = CW'(DEPTH / 2);

    always_comb begin
        empty     = (occ == '0);
        full      = (occ == FULL_C);
        half_full = (occ > HALF_C);
    end

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
    import replay_fifo_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rewind_n,
    output logic             empty,
    output logic             half_full,
    output logic             full
);

    localparam int AW = $clog2(DEPTH);

    generate
        if (!depth_supported(DEPTH)) begin : g_bad_depth
            $error("replay_fifo: DEPTH must be 256, 512 or 1024");
        end
    endgenerate

    logic          push;
    logic          pop;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   occ;

    replay_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rewind_n (rewind_n),
        .is_empty (empty),
        .is_full  (full),
        .push     (push),
        .pop      (pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .occ      (occ)
    );

    replay_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .re    (pop),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    replay_fifo_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
        .occ       (occ),
        .empty     (empty),
        .half_full (half_full),
        .full      (full)
    );

endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rewind_n,
    input logic [WIDTH-1:0] rd_data,
    input logic             empty,
    input logic             half_full,
    input logic             full,
    input logic [AW:0]      occ
);

    localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (empty && !full && !half_full && rd_data == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en && rewind_n) |=> full);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en && rewind_n) |=> (empty && $stable(rd_data)));

    p_full_implies_half_r5: assert property (@(posedge clk) disable iff (rst)
        full |-> (half_full && !empty));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    p_occ_bound_r6: assert property (@(posedge clk) disable iff (rst)
        occ <= DEPTH_C);

    p_both_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (!empty && !full && wr_en && rd_en && rewind_n) |=> $stable(occ));

    p_empty_both_r8: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en && rd_en && rewind_n) |=> (!empty && $stable(rd_data)));

    p_full_both_r9: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && rd_en && rewind_n) |=> (full && $stable(occ)));

    p_rewind_grow_r10: assert property (@(posedge clk) disable iff (rst)
        !rewind_n |=> (occ >= $past(occ) && $stable(rd_data)));

endmodule

bind replay_fifo replay_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rewind_n  (rewind_n),
    .rd_data   (rd_data),
    .empty     (empty),
    .half_full (half_full),
    .full      (full),
    .occ       (occ)
);

// File: tb/sim_replay_fifo.sv
module sim_replay_fifo;

    localparam int DEPTH = 256;
    localparam int WIDTH = 9;
    localparam int HALF  = DEPTH / 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en;
    logic [WIDTH-1:0] wr_data;
    logic             rd_en;
    logic [WIDTH-1:0] rd_data;
    logic             rewind_n;
    logic             empty;
    logic             half_full;
    logic             full;

    always #2 clk = ~clk;

    replay_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rewind_n  (rewind_n),
        .empty     (empty),
        .half_full (half_full),
        .full      (full)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model of the buffer, built from the requirements.
    logic [WIDTH-1:0] mm [DEPTH];
    int               mw, mr, mc;

    logic [WIDTH-1:0] exp_q [$];
    string            tag_q [$];
    event             rd_done;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic print_summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; rewind_n = 1'b1; wr_data = '0;
        @(posedge clk);
        #1;
        check(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
        check(full == 1'b0, "R1", "full after reset", int'(full), 0);
        check(half_full == 1'b0, "R1", "half_full after reset", int'(half_full), 0);
        check(rd_data == '0, "R1", "rd_data after reset", int'(rd_data), 0);
        @(negedge clk);
        rst = 1'b0;
        mw = 0; mr = 0; mc = 0;
    endtask

    // Driver: applies one cycle of stimulus, predicts the outcome and
    // queues the expected word for the monitor.
    task automatic step(input bit wr, input logic [WIDTH-1:0] din, input bit rd,
                        input bit rn, input string tag);
        bit               rew, wacc, racc;
        logic [WIDTH-1:0] prev;
        @(negedge clk);
        wr_en = wr; wr_data = din; rd_en = rd; rewind_n = rn;
        prev = rd_data;
        rew  = !rn;
        wacc = !rew && wr && ((mc < DEPTH) || rd);
        racc = !rew && rd && (mc > 0);
        if (racc) begin
            exp_q.push_back(mm[mr]);
            tag_q.push_back(tag);
        end
        if (rew) begin
            mr = 0;
            mc = mw;
        end else begin
            if (wacc) begin
                mm[mw] = din;
                mw = (mw + 1) % DEPTH;
            end
            if (racc) mr = (mr + 1) % DEPTH;
            mc = mc + int'(wacc) - int'(racc);
        end
        @(posedge clk);
        #1;
        if (racc) ->rd_done;
        else check(rd_data == prev, tag, "rd_data held", int'(rd_data), int'(prev));
        check(empty == (mc == 0), "R6", "empty flag", int'(empty), int'(mc == 0));
        check(full == (mc == DEPTH), "R6", "full flag", int'(full), int'(mc == DEPTH));
        check(half_full == (mc > HALF), "R5", "half_full flag", int'(half_full), int'(mc > HALF));
    endtask

    // Monitor: compares each word the design reads out with the queue head.
    initial begin
        forever begin
            logic [WIDTH-1:0] e;
            string            t;
            @(rd_done);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data == e, t, "word read out", int'(rd_data), int'(e));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        print_summary();
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; rewind_n = 1'b1; wr_data = '0;
        do_reset();

        // R4: a read on an empty buffer is ignored
        step(1'b0, '0, 1'b1, 1'b1, "R4");

        // R2: basic ordering with bit 8 in use
        for (int i = 0; i < 5; i++) step(1'b1, 9'(9'h1A0 + i * 7), 1'b0, 1'b1, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b1, "R2");

        // R7: a read and a write together in mid occupancy
        for (int i = 0; i < 4; i++) step(1'b1, 9'(9'h0C3 + i * 29), 1'b1, 1'b1, "R7");
        while (mc > 0) step(1'b0, '0, 1'b1, 1'b1, "R2");

        // R8: a read and a write together on an empty buffer
        step(1'b1, 9'h1FF, 1'b1, 1'b1, "R8");
        step(1'b0, '0, 1'b1, 1'b1, "R8");

        // R10: replay from the first word written since reset
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b1, 9'(9'h111 + i * 13), 1'b0, 1'b1, "R10");
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b1, "R10");
        step(1'b1, 9'h055, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1, 1'b1, "R10");
        step(1'b0, '0, 1'b1, 1'b1, "R10");

        // R5 and R6: half-full threshold and capacity
        do_reset();
        for (int i = 0; i < HALF; i++) step(1'b1, 9'(i * 3 + 256), 1'b0, 1'b1, "R5");
        step(1'b1, 9'h17E, 1'b0, 1'b1, "R5");
        for (int i = HALF + 1; i < DEPTH; i++) step(1'b1, 9'(i * 5), 1'b0, 1'b1, "R6");

        // R3: a write on a full buffer is ignored
        step(1'b1, 9'h0AA, 1'b0, 1'b1, "R3");

        // R9: a read and a write together on a full buffer
        step(1'b1, 9'h133, 1'b1, 1'b1, "R9");

        // R11: drain past the end of storage, then keep streaming
        while (mc > 0) step(1'b0, '0, 1'b1, 1'b1, "R11");
        for (int i = 0; i < 20; i++) step(1'b1, 9'(9'h1C0 + i), 1'b0, 1'b1, "R11");
        for (int i = 0; i < 20; i++) step(1'b0, '0, 1'b1, 1'b1, "R11");

        step(1'b0, '0, 1'b0, 1'b1, "R2");
        print_summary();
        $finish;
    end

endmodule